// File: doc/BRIEF.md
# Four-Core Work Dispatch Arbiter

This block takes 64-bit work words that a host pushes into one shared input buffer and hands each word to one of four compute cores. Every core owns a private downlink FIFO. A word moves only into a FIFO whose used-word count leaves room for it. When several cores could take the word, a rotating pointer chooses among them, so the load spreads evenly and no core waits forever.

A small register file controls the block. Through a command register the host can configure, start, stop or reset any subset of cores, and it can also empty the shared buffer. A configuration register holds a value that the cores sample on their configure strobe. A status register reports the fill level of the shared buffer and the empty and full state of every core FIFO. Each core drains its FIFO through a show-ahead read port. The data word is valid whenever the empty flag is low.

Top module: `mcd_dispatch`

## Requirements
- R1: After reset the shared buffer and all four core FIFOs are empty, dispatch is disabled for every core, the configuration register is zero and no command strobe is high.
- R2: A host write (`hw_en` high) appends `hw_data` to the shared buffer unless the buffer already holds BUF_DEPTH (16) words. A write to a full buffer is dropped. The buffer-full flag is status bit 28.
- R3: Each word leaves the shared buffer toward exactly one core, and only toward a core that has been started. Every core receives its words in the order the host wrote them.
- R4: When several started cores can take a word in the same cycle, the first one at or after a rotating pointer gets it, counting upward from core 0 and wrapping. The pointer then moves to the core after the one chosen. The pointer is 0 after reset.
- R5: A core FIFO is offered a word only while its used-word count is below CORE_DEPTH-2. With a steady supply and no reads, a core FIFO settles at CORE_DEPTH-1 (7) words, and it is never written while full.
- R6: A word written into an empty shared buffer at clock edge n, bound for an eligible core with an empty FIFO, makes that core's `core_empty` fall after edge n+2.
- R7: The command register is at address 0. Bits [3:0] select cores (bit i = core i). Bits [9:8] select the operation: 0 configure, 1 start, 2 stop, 3 reset. Bit 12 requests a shared-buffer flush. A write raises the matching strobe for each selected core during exactly the one cycle that follows the write edge.
- R8: Start enables dispatch to the selected cores. Stop disables it and leaves the words already in those core FIFOs in place.
- R9: Reset empties the selected core FIFOs, including a word already on its way, and disables dispatch to them.
- R10: A command write with bit 12 set empties the shared buffer. Stored words are then never delivered.
- R11: Address 1 is a read/write configuration register whose value is driven on `core_cfg`.
- R12: Address 2 reads the status: [15:0] shared-buffer word count, [19:16] core FIFO empty flags, [23:20] core FIFO full flags, [27:24] dispatch-enabled mask, [28] shared-buffer full. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_en | input | 1 | Host data write enable |
| hw_data | input | 64 | Host data word |
| reg_en | input | 1 | Register access enable |
| reg_we | input | 1 | Register write when high |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| core_rd | input | 4 | Per-core FIFO read strobe |
| core_data | output | 256 | Per-core head word, core i at bits [64*i+63:64*i] |
| core_empty | output | 4 | Per-core FIFO empty flag |
| cmd_cfg | output | 4 | Per-core configure strobe |
| cmd_start | output | 4 | Per-core start strobe |
| cmd_stop | output | 4 | Per-core stop strobe |
| cmd_rst | output | 4 | Per-core reset strobe |
| core_cfg | output | 32 | Configuration value for the cores |

## Verification
The assertions assume that cores raise `core_rd` only while their `core_empty` is low. A read to an empty FIFO is dropped, so the state checks still hold if this is broken, but the scoreboard's view would no longer match. They also assume the host writes one register at a time. The bench monitor raises a read only on a non-empty FIFO whose expected queue is open, and its drivers issue each register write alone, one cycle wide, away from the clock edge. The rotation model in the bench predicts the target core only while every started core is being drained. For that reason the fill-limit test runs with a single started core.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  parameter int unsigned MCD_CORES = 4;
  parameter int unsigned MCD_REG_W = 32;

  localparam logic [1:0] ADDR_CMD    = 2'd0;
  localparam logic [1:0] ADDR_CFG    = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;
  localparam int unsigned FLUSH_BIT  = 12;

  typedef enum logic [1:0] {
    OP_CONFIGURE = 2'd0,
    OP_START     = 2'd1,
    OP_STOP      = 2'd2,
    OP_RESET     = 2'd3
  } mcd_op_e;

  // A core FIFO may be offered a word while it keeps a two-word margin.
  function automatic logic fifo_can_take(input int unsigned used, input int unsigned depth);
    return used + 2 < depth;
  endfunction

  // One-hot pick: first requester at or after ptr, wrapping.
  function automatic logic [MCD_CORES-1:0] rr_pick(input logic [MCD_CORES-1:0] req,
                                                   input int unsigned ptr);
    logic [MCD_CORES-1:0] g;
    logic hit;
    g = '0;
    hit = 1'b0;
    for (int k = 0; k < MCD_CORES; k++) begin
      if (!hit && req[(ptr + k) % MCD_CORES]) begin
        g[(ptr + k) % MCD_CORES] = 1'b1;
        hit = 1'b1;
      end
    end
    return g;
  endfunction
endpackage

// File: rtl/mcd_fifo.sv
module mcd_fifo #(
  parameter int unsigned W     = 64,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  input  logic          rd,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_wr, do_rd;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign do_wr = wr && !full && !flush;
  assign do_rd = rd && !empty && !flush;
  assign rdata = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) rptr <= rptr + 1'b1;
      count <= count + CW'(do_wr) - CW'(do_rd);
    end
  end
endmodule

// File: rtl/mcd_rr_arb.sv
module mcd_rr_arb
  import mcd_pkg::*;
#(
  parameter int unsigned N = MCD_CORES,
  localparam int unsigned PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  logic [PW-1:0] ptr;
  logic [PW-1:0] next_ptr;

  assign grant = rr_pick(req, int'(ptr));

  always_comb begin
    next_ptr = ptr;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) next_ptr = PW'((i + 1) % N);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= next_ptr;
  end
endmodule

// File: rtl/mcd_regs.sv
module mcd_regs
  import mcd_pkg::*;
#(
  parameter int unsigned N   = MCD_CORES,
  parameter int unsigned BCW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_en,
  input  logic                 reg_we,
  input  logic [1:0]           reg_addr,
  input  logic [MCD_REG_W-1:0] reg_wdata,
  output logic [MCD_REG_W-1:0] reg_rdata,
  input  logic [BCW-1:0]       buf_count,
  input  logic                 buf_full,
  input  logic [N-1:0]         core_empty,
  input  logic [N-1:0]         core_full,
  output logic [N-1:0]         core_en,
  output logic [MCD_REG_W-1:0] core_cfg,
  output logic [N-1:0]         cmd_cfg,
  output logic [N-1:0]         cmd_start,
  output logic [N-1:0]         cmd_stop,
  output logic [N-1:0]         cmd_rst,
  output logic                 buf_flush
);
  logic    cmd_wr, cfg_wr;
  logic [N-1:0] sel;
  mcd_op_e op;

  assign cmd_wr = reg_en && reg_we && (reg_addr == ADDR_CMD);
  assign cfg_wr = reg_en && reg_we && (reg_addr == ADDR_CFG);
  assign sel    = reg_wdata[N-1:0];
  assign op     = mcd_op_e'(reg_wdata[9:8]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_en   <= '0;
      core_cfg  <= '0;
      cmd_cfg   <= '0;
      cmd_start <= '0;
      cmd_stop  <= '0;
      cmd_rst   <= '0;
      buf_flush <= 1'b0;
    end else begin
      cmd_cfg   <= '0;
      cmd_start <= '0;
      cmd_stop  <= '0;
      cmd_rst   <= '0;
      buf_flush <= cmd_wr && reg_wdata[FLUSH_BIT];
      if (cfg_wr) core_cfg <= reg_wdata;
      if (cmd_wr) begin
        unique case (op)
          OP_CONFIGURE: cmd_cfg <= sel;
          OP_START: begin
            cmd_start <= sel;
            core_en   <= core_en | sel;
          end
          OP_STOP: begin
            cmd_stop <= sel;
            core_en  <= core_en & ~sel;
          end
          OP_RESET: begin
            cmd_rst <= sel;
            core_en <= core_en & ~sel;
          end
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CFG: reg_rdata = core_cfg;
      ADDR_STATUS: begin
        reg_rdata[15:0]  = 16'(buf_count);
        reg_rdata[19:16] = 4'(core_empty);
        reg_rdata[23:20] = 4'(core_full);
        reg_rdata[27:24] = 4'(core_en);
        reg_rdata[28]    = buf_full;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mcd_dispatch.sv
module mcd_dispatch
  import mcd_pkg::*;
#(
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned BUF_DEPTH  = 16,
  parameter int unsigned CORE_DEPTH = 8,
  localparam int unsigned NC  = MCD_CORES,
  localparam int unsigned BCW = $clog2(BUF_DEPTH + 1),
  localparam int unsigned CCW = $clog2(CORE_DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hw_en,
  input  logic [DATA_W-1:0]      hw_data,
  input  logic                   reg_en,
  input  logic                   reg_we,
  input  logic [1:0]             reg_addr,
  input  logic [MCD_REG_W-1:0]   reg_wdata,
  output logic [MCD_REG_W-1:0]   reg_rdata,
  input  logic [NC-1:0]          core_rd,
  output logic [NC*DATA_W-1:0]   core_data,
  output logic [NC-1:0]          core_empty,
  output logic [NC-1:0]          cmd_cfg,
  output logic [NC-1:0]          cmd_start,
  output logic [NC-1:0]          cmd_stop,
  output logic [NC-1:0]          cmd_rst,
  output logic [MCD_REG_W-1:0]   core_cfg
);
  // Named internal events, also used by the bound checker.
  logic [BCW-1:0]          buf_count;
  logic                    buf_empty, buf_full, buf_pop, buf_flush;
  logic [DATA_W-1:0]       buf_head;
  logic [NC-1:0]           core_en, core_full, eligible, grant, core_wr;
  logic [NC-1:0][CCW-1:0]  core_cnt;
  logic [DATA_W-1:0]       stg_data;

  mcd_fifo #(.W(DATA_W), .DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .flush(buf_flush),
    .wr(hw_en), .wdata(hw_data), .rd(buf_pop), .rdata(buf_head),
    .count(buf_count), .empty(buf_empty), .full(buf_full)
  );

  always_comb begin
    for (int i = 0; i < NC; i++) begin
      eligible[i] = core_en[i] && !buf_empty && !buf_flush &&
                    fifo_can_take(int'(core_cnt[i]), CORE_DEPTH);
    end
  end

  mcd_rr_arb #(.N(NC)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(eligible), .grant(grant)
  );

  assign buf_pop = |grant;

  // One register stage between the shared buffer and the core FIFOs.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_wr  <= '0;
      stg_data <= '0;
    end else begin
      core_wr <= grant;
      if (buf_pop) stg_data <= buf_head;
    end
  end

  for (genvar g = 0; g < NC; g++) begin : g_core
    mcd_fifo #(.W(DATA_W), .DEPTH(CORE_DEPTH)) u_cfifo (
      .clk(clk), .rst_n(rst_n), .flush(cmd_rst[g]),
      .wr(core_wr[g]), .wdata(stg_data), .rd(core_rd[g]),
      .rdata(core_data[g*DATA_W +: DATA_W]),
      .count(core_cnt[g]), .empty(core_empty[g]), .full(core_full[g])
    );
  end

  mcd_regs #(.N(NC), .BCW(BCW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .buf_count(buf_count), .buf_full(buf_full),
    .core_empty(core_empty), .core_full(core_full),
    .core_en(core_en), .core_cfg(core_cfg),
    .cmd_cfg(cmd_cfg), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_rst(cmd_rst), .buf_flush(buf_flush)
  );
endmodule

// File: rtl/mcd_dispatch_checker.sv
module mcd_dispatch_checker #(
  parameter int unsigned NC        = 4,
  parameter int unsigned BCW       = 5,
  parameter int unsigned BUF_DEPTH = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NC-1:0]  grant,
  input logic [NC-1:0]  core_en,
  input logic [NC-1:0]  core_wr,
  input logic [NC-1:0]  core_full,
  input logic [NC-1:0]  core_empty,
  input logic [NC-1:0]  cmd_stop,
  input logic [NC-1:0]  cmd_rst,
  input logic [BCW-1:0] buf_count,
  input logic           buf_pop,
  input logic           buf_empty
);
  a_r3_single_target: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));
  a_r3_pop_has_word: assert property (@(posedge clk) disable iff (!rst_n) buf_pop |-> !buf_empty);
  a_r2_buffer_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    int'(buf_count) <= BUF_DEPTH);

  for (genvar i = 0; i < NC; i++) begin : g_chk
    a_r3_started_only: assert property (@(posedge clk) disable iff (!rst_n)
      grant[i] |-> core_en[i]);
    a_r5_no_write_full: assert property (@(posedge clk) disable iff (!rst_n)
      core_wr[i] |-> !core_full[i]);
    a_r8_stop_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stop[i] |-> !grant[i]);
    a_r9_reset_empties: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_rst[i] |=> core_empty[i]);
  end
endmodule

bind mcd_dispatch mcd_dispatch_checker #(.NC(NC), .BCW(BCW), .BUF_DEPTH(BUF_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .grant(grant), .core_en(core_en), .core_wr(core_wr),
  .core_full(core_full), .core_empty(core_empty), .cmd_stop(cmd_stop), .cmd_rst(cmd_rst),
  .buf_count(buf_count), .buf_pop(buf_pop), .buf_empty(buf_empty)
);

// File: tb/mcd_dispatch_bench.sv
module mcd_dispatch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_en = 1'b0;
  logic [DW-1:0] hw_data = '0;
  logic reg_en = 1'b0, reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NC-1:0] core_rd = '0;
  logic [NC*DW-1:0] core_data;
  logic [NC-1:0] core_empty, cmd_cfg, cmd_start, cmd_stop, cmd_rst;
  logic [31:0] core_cfg;

  int checks = 0;
  int errors = 0;
  bit drain = 1'b0;
  bit done = 1'b0;
  int rr_next = 0;
  int word_id = 0;
  logic [DW-1:0] exp_q[NC][$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mcd_dispatch u_mcd_dispatch (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .hw_data(hw_data),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .core_rd(core_rd), .core_data(core_data),
    .core_empty(core_empty), .cmd_cfg(cmd_cfg), .cmd_start(cmd_start),
    .cmd_stop(cmd_stop), .cmd_rst(cmd_rst), .core_cfg(core_cfg)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  function automatic logic [DW-1:0] word_of(input int k);
    return 64'hC0DE_0000_0000_0000 + 64'(k) * 64'h0001_0000_0001;
  endfunction

  // Scoreboard producer: the target is the first started core at or after
  // the rotating position (R4), valid while all started cores are drained.
  task automatic expect_to(input logic [NC-1:0] started, input logic [DW-1:0] w);
    for (int k = 0; k < NC; k++) begin
      if (started[(rr_next + k) % NC]) begin
        int t;
        t = (rr_next + k) % NC;
        exp_q[t].push_back(w);
        rr_next = (t + 1) % NC;
        return;
      end
    end
  endtask

  task automatic host_write(input int n, input bit score, input logic [NC-1:0] started);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      hw_en = 1'b1;
      hw_data = word_of(word_id);
      if (score) expect_to(started, hw_data);
      word_id++;
    end
    @(negedge clk);
    hw_en = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    reg_en = 1'b0;
  endtask

  function automatic logic [31:0] cmd(input logic [3:0] sel, input logic [1:0] op);
    return {22'd0, op, 4'd0, sel};
  endfunction

  task automatic wait_drained();
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (exp_q[0].size() == 0 && exp_q[1].size() == 0 &&
          exp_q[2].size() == 0 && exp_q[3].size() == 0) return;
    end
    check(1'b0, "R3 delivery incomplete", 64'(exp_q[0].size() + exp_q[1].size()), 64'd0);
  endtask

  // Scoreboard consumer.
  initial begin
    forever begin
      @(negedge clk);
      core_rd = '0;
      if (drain && rst_n) begin
        for (int i = 0; i < NC; i++) begin
          if (!core_empty[i]) begin
            if (exp_q[i].size() == 0) begin
              check(1'b0, $sformatf("R3 unexpected word core %0d", i), core_data[i*DW +: DW], '0);
            end else begin
              logic [DW-1:0] e;
              e = exp_q[i].pop_front();
              check(core_data[i*DW +: DW] == e, $sformatf("R3 R4 word at core %0d", i),
                    core_data[i*DW +: DW], e);
            end
            core_rd[i] = 1'b1;
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 64'd0, 64'd1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_read(2'd2, st);
    check(st == 32'h000F_0000, "R1 R12 status after reset", 64'(st), 64'h000F_0000);
    check(core_empty == 4'hF, "R1 core empty", 64'(core_empty), 64'hF);
    check({cmd_cfg, cmd_start, cmd_stop, cmd_rst} == '0, "R1 strobes idle",
          64'({cmd_cfg, cmd_start, cmd_stop, cmd_rst}), 64'd0);
    check(core_cfg == 32'd0, "R1 config zero", 64'(core_cfg), 64'd0);
    reg_read(2'd3, st);
    check(st == 32'd0, "R12 address 3 reads zero", 64'(st), 64'd0);

    // R11 configuration register and R7 configure strobe
    reg_write(2'd1, 32'hA5A5_0F0F);
    reg_read(2'd1, st);
    check(st == 32'hA5A5_0F0F, "R11 config readback", 64'(st), 64'hA5A5_0F0F);
    check(core_cfg == 32'hA5A5_0F0F, "R11 core_cfg drive", 64'(core_cfg), 64'hA5A5_0F0F);
    reg_write(2'd0, cmd(4'b1011, 2'd0));
    check(cmd_cfg == 4'b1011, "R7 configure strobe", 64'(cmd_cfg), 64'b1011);
    @(negedge clk);
    check(cmd_cfg == 4'b0000, "R7 strobe one cycle", 64'(cmd_cfg), 64'd0);

    // R3 no dispatch to unstarted cores
    host_write(3, 1'b0, 4'h0);
    repeat (5) @(negedge clk);
    reg_read(2'd2, st);
    check(st[15:0] == 16'd3, "R2 R3 words held while no core started", 64'(st[15:0]), 64'd3);
    check(core_empty == 4'hF, "R3 no core receives", 64'(core_empty), 64'hF);

    // R8 start all; R4 rotation under drain
    for (int k = 0; k < 3; k++) expect_to(4'hF, word_of(k));
    drain = 1'b1;
    reg_write(2'd0, cmd(4'hF, 2'd1));
    check(cmd_start == 4'hF, "R7 R8 start strobe", 64'(cmd_start), 64'hF);
    host_write(9, 1'b1, 4'hF);
    wait_drained();

    // R5 fill limit with only core 0 started, no reads
    drain = 1'b0;
    reg_write(2'd0, cmd(4'b1110, 2'd2));
    check(cmd_stop == 4'b1110, "R7 R8 stop strobe", 64'(cmd_stop), 64'b1110);
    begin
      int first;
      first = word_id;
      host_write(10, 1'b0, 4'h1);
      repeat (20) @(negedge clk);
      reg_read(2'd2, st);
      check(st[15:0] == 16'd3, "R5 core settles at depth-1", 64'(st[15:0]), 64'd3);
      check(st[19:16] == 4'b1110, "R3 stopped cores stay empty", 64'(st[19:16]), 64'b1110);
      check(st[23:20] == 4'b0000, "R5 core FIFO not full", 64'(st[23:20]), 64'd0);
      // R8 stop keeps contents
      reg_write(2'd0, cmd(4'b0001, 2'd2));
      repeat (3) @(negedge clk);
      reg_read(2'd2, st);
      check(st[16] == 1'b0, "R8 stop keeps words", 64'(st[16]), 64'd0);
      check(st[15:0] == 16'd3, "R8 stopped core takes nothing", 64'(st[15:0]), 64'd3);
      // R9 reset flushes
      reg_write(2'd0, cmd(4'b0001, 2'd3));
      check(cmd_rst == 4'b0001, "R7 R9 reset strobe", 64'(cmd_rst), 64'b0001);
      @(negedge clk);
      reg_read(2'd2, st);
      check(st[19:16] == 4'hF, "R9 core 0 emptied", 64'(st[19:16]), 64'hF);
      check(st[27:24] == 4'h0, "R9 dispatch disabled", 64'(st[27:24]), 64'h0);
      for (int k = 7; k < 10; k++) exp_q[0].push_back(word_of(first + k));
      drain = 1'b1;
      reg_write(2'd0, cmd(4'b0001, 2'd1));
      wait_drained();
    end

    // R2 full buffer drops writes; R10 flush
    drain = 1'b0;
    reg_write(2'd0, cmd(4'hF, 2'd2));
    host_write(18, 1'b0, 4'h0);
    @(negedge clk);
    reg_read(2'd2, st);
    check(st[15:0] == 16'd16, "R2 buffer caps at depth", 64'(st[15:0]), 64'd16);
    check(st[28] == 1'b1, "R2 R12 buffer full flag", 64'(st[28]), 64'd1);
    reg_write(2'd0, 32'h0000_1000);
    @(negedge clk);
    reg_read(2'd2, st);
    check(st[15:0] == 16'd0, "R10 buffer flushed", 64'(st[15:0]), 64'd0);
    check(st[28] == 1'b0, "R10 full flag cleared", 64'(st[28]), 64'd0);

    // R6 latency to core 2 and R10 flushed words never appear
    reg_write(2'd0, cmd(4'b0100, 2'd1));
    repeat (4) @(negedge clk);
    check(core_empty == 4'hF, "R10 flushed words not delivered", 64'(core_empty), 64'hF);
    @(negedge clk);
    hw_en = 1'b1;
    hw_data = word_of(500);
    @(negedge clk);
    hw_en = 1'b0;
    check(core_empty[2] == 1'b1, "R6 empty after edge n", 64'(core_empty[2]), 64'd1);
    @(negedge clk);
    check(core_empty[2] == 1'b1, "R6 empty after edge n+1", 64'(core_empty[2]), 64'd1);
    @(negedge clk);
    check(core_empty[2] == 1'b0, "R6 data after edge n+2", 64'(core_empty[2]), 64'd0);
    exp_q[2].push_back(word_of(500));
    drain = 1'b1;
    wait_drained();
    repeat (3) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule